// File: doc/BRIEF.md
# Ready/Busy Status Pin Controller

This block drives the open-drain status pin of a flash-style operation engine. The pin is active low: a value of 0 on `sts_n_o` means the pin is pulled low, and 1 means it is released. A two-bit mode, loaded through a configuration write, selects one of two behaviours. The pin can show a continuous busy level, or it can stay released and emit one fixed-width low pulse when a selected class of operation (program, erase, or either) completes.

The engine supplies a busy flag and single-cycle completion strobes tagged as program or erase. The host writes the mode with a dedicated command cycle, which appears here as `cfg_wr_i` with the mode in the two lowest data bits. A mode written while an operation is in flight does not disturb the current indication. It takes over at that operation's completion, and that completion is already judged by the new mode.

Top module: `rdy_sts_ctrl`

## Requirements
- R1: After reset the mode is 00 (level) and `sts_n_o` is 1; a busy flag sampled after reset pulls the pin to 0.
- R2: The mode register loads only on a clock edge with `cfg_wr_i` = 1, and it takes bits [1:0] of `cfg_data_i`; the upper data bits are ignored, and so is the data bus when no write is made.
- R3: In mode 00, `sts_n_o` is the inverse of `busy_i` as sampled at the previous clock edge, whether or not any completion strobe occurs.
- R4: In mode 01, an `erase_done_i` strobe with `busy_i` low drives `sts_n_o` to 0 for exactly PULSE_W cycles, starting the cycle after the strobe; `prog_done_i` has no effect.
- R5: In mode 10, a `prog_done_i` strobe gives the same PULSE_W-cycle low pulse; `erase_done_i` has no effect.
- R6: In mode 11, either completion strobe gives the PULSE_W-cycle low pulse.
- R7: A qualifying completion that arrives during a pulse restarts it, so the pin stays at 0 for PULSE_W full cycles after the later strobe.
- R8: In modes 01, 10 and 11, `sts_n_o` is 1 while an operation is busy.
- R9: A mode written while `busy_i` is high leaves the current indication unchanged until the next completion strobe, and that completion is qualified by the new mode.
- R10: A mode written while the engine is idle governs the pin from the next clock edge.
- R11: Switching to mode 00 while a pulse is running ends the pulse at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Operation engine busy flag |
| prog_done_i | input | 1 | Single-cycle program completion strobe |
| erase_done_i | input | 1 | Single-cycle erase completion strobe |
| cfg_wr_i | input | 1 | Mode configuration write strobe |
| cfg_data_i | input | DATA_W | Configuration data; bits [1:0] carry the mode |
| sts_n_o | output | 1 | Status pin, 0 = pulled low, 1 = released |

## Verification
The bench sweeps every mode against every combination of completion strobes, and checks the pin before, during and after a busy period. A design that qualifies strobes by the wrong type produces stray pulses or misses pulses. A design with an off-by-one pulse counter gives pulses one cycle too short or too long. Further directed cases cover the mode rewritten in mid-operation in both directions: a design that applies the write at once flips the pin while the engine is busy, and one that qualifies the completion by the old mode loses the pulse. The remaining cases cover a retrigger that lands in the middle of a pulse, which a non-restarting counter cuts short, and a switch to level mode during a pulse, which a design that forgets to clear the counter turns into a stuck low pin.

// File: rtl/rdy_sts_ctrl.sv
module rdy_sts_ctrl #(
  parameter int PULSE_W = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              prog_done_i,
  input  logic              erase_done_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              sts_n_o
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [1:0] M_LEVEL = 2'b00;
  localparam logic [1:0] M_ERASE = 2'b01;
  localparam logic [1:0] M_PROG  = 2'b10;
  localparam logic [1:0] M_ANY   = 2'b11;

  logic [1:0]    cfg_q, mode_q, pend, eff;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_any, hold, hit;

  // latest programmed mode, and the mode that governs the pin this edge
  assign pend     = cfg_wr_i ? cfg_data_i[1:0] : cfg_q;
  assign done_any = prog_done_i | erase_done_i;
  assign hold     = busy_i & ~done_any;
  assign eff      = hold ? mode_q : pend;

  assign hit = ((pend == M_ERASE) & erase_done_i) |
               ((pend == M_PROG)  & prog_done_i)  |
               ((pend == M_ANY)   & done_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= M_LEVEL;
      mode_q <= M_LEVEL;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cfg_q  <= pend;
      mode_q <= eff;
      busy_q <= busy_i;
      if (hit)
        cnt_q <= CW'(PULSE_W);
      else if (busy_i || eff == M_LEVEL)
        cnt_q <= '0;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sts_n_o = (mode_q == M_LEVEL) ? ~busy_q : ~((cnt_q != '0) & ~busy_q);
endmodule

// File: rtl/rdy_sts_ctrl_chk.sv
module rdy_sts_ctrl_chk #(
  parameter int PULSE_W = 4,
  parameter int CW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          prog_done_i,
  input logic          erase_done_i,
  input logic          cfg_wr_i,
  input logic [1:0]    cfg_q,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] cnt_q,
  input logic          sts_n_o
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_i |=> $stable(cfg_q)); // R2
  AST_LEVEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && cfg_q == 2'b00 && mode_q == 2'b00 && !cfg_wr_i) |=> !sts_n_o); // R3
  AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && erase_done_i && !cfg_wr_i && cfg_q == 2'b01) |=> !sts_n_o); // R4
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && prog_done_i && !cfg_wr_i && cfg_q == 2'b10) |=> !sts_n_o); // R5
  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !prog_done_i && !erase_done_i && mode_q != 2'b00) |=> sts_n_o); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSE_W)); // R7
endmodule

bind rdy_sts_ctrl rdy_sts_ctrl_chk #(.PULSE_W(PULSE_W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .prog_done_i(prog_done_i),
  .erase_done_i(erase_done_i), .cfg_wr_i(cfg_wr_i), .cfg_q(cfg_q),
  .mode_q(mode_q), .cnt_q(cnt_q), .sts_n_o(sts_n_o)
);

// File: tb/rdy_sts_ctrl_tb_top.sv
`timescale 1ns/1ps
module rdy_sts_ctrl_tb_top;
  localparam int PW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic busy = 1'b0, pd = 1'b0, ed = 1'b0, wr = 1'b0;
  logic [7:0] d = 8'h00;
  logic sts_n;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rdy_sts_ctrl #(.PULSE_W(PW), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .prog_done_i(pd),
    .erase_done_i(ed), .cfg_wr_i(wr), .cfg_data_i(d), .sts_n_o(sts_n)
  );

  task automatic cyc(input logic b, input logic p, input logic e,
                     input logic w = 1'b0, input logic [7:0] dat = 8'h00);
    busy = b; pd = p; ed = e; wr = w; d = dat;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (sts_n !== exp) begin
      errors++;
      $display("FAIL %s: sts_n_o=%b expected=%b at %0t", req, sts_n, exp, $time);
    end
  endtask

  task automatic drain();
    repeat (PW + 2) cyc(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b1, "R1 in reset");
    busy = 1'b0; rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0); chk(1'b1, "R1 idle after reset");
    cyc(1'b1, 1'b0, 1'b0); chk(1'b0, "R1 default level mode");
    cyc(1'b0, 1'b0, 1'b0); chk(1'b1, "R3 release");

    // R2: data bus without write is ignored
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h03); chk(1'b0, "R2 no write");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00); chk(1'b1, "R2 level kept");

    for (int m = 0; m < 4; m++) begin
      for (int dc = 0; dc < 4; dc++) begin
        logic p, e, q;
        string tag;
        p = dc[1]; e = dc[0];
        q = (m == 1 && e) || (m == 2 && p) || (m == 3 && (p || e));
        tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
        drain();
        cyc(1'b0, 1'b0, 1'b0, 1'b1, {6'b101101, 2'(m)});
        chk(1'b1, "R2 idle after write");
        for (int i = 0; i < 3; i++) begin
          cyc(1'b1, 1'b0, 1'b0);
          chk((m == 0) ? 1'b0 : 1'b1, (m == 0) ? "R3 busy" : "R8 busy");
        end
        cyc(1'b0, p, e);
        for (int k = 1; k <= PW + 2; k++) begin
          if (k > 1) cyc(1'b0, 1'b0, 1'b0);
          chk((q && k <= PW) ? 1'b0 : 1'b1, tag);
        end
      end
    end

    // R7: retrigger mid-pulse
    drain();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
    cyc(1'b0, 1'b1, 1'b0); chk(1'b0, "R7 first");
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= PW + 1; k++) begin
      if (k > 1) cyc(1'b0, 1'b0, 1'b0);
      chk((k <= PW) ? 1'b0 : 1'b1, "R7 restart");
    end

    // R9: level -> erase-pulse written while busy
    drain();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 1'b0); chk(1'b0, "R9 busy level");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h01); chk(1'b0, "R9 held old mode");
    cyc(1'b1, 1'b0, 1'b0); chk(1'b0, "R9 held old mode");
    cyc(1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= PW + 1; k++) begin
      if (k > 1) cyc(1'b0, 1'b0, 1'b0);
      chk((k <= PW) ? 1'b0 : 1'b1, "R9 new mode qualifies");
    end

    // R9: erase-pulse -> level written while busy
    drain();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    cyc(1'b1, 1'b0, 1'b0); chk(1'b1, "R9 pulse mode busy");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00); chk(1'b1, "R9 held pulse mode");
    cyc(1'b1, 1'b0, 1'b0); chk(1'b1, "R9 held pulse mode");
    cyc(1'b0, 1'b0, 1'b1); chk(1'b1, "R9 no pulse in new mode");
    cyc(1'b1, 1'b0, 1'b0); chk(1'b0, "R9 level after completion");

    // R10: idle write governs next edge
    drain();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h02);
    cyc(1'b1, 1'b0, 1'b0); chk(1'b1, "R10 immediate");
    cyc(1'b0, 1'b1, 1'b0); chk(1'b0, "R10 program pulse");

    // R11: switch to level during pulse
    drain();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    cyc(1'b0, 1'b0, 1'b1); chk(1'b0, "R11 pulse");
    cyc(1'b0, 1'b0, 1'b0); chk(1'b0, "R11 pulse");
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00); chk(1'b1, "R11 cancelled");
    cyc(1'b0, 1'b0, 1'b0); chk(1'b1, "R11 stays released");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule